// File: doc/BRIEF.md
# Half-Word Packer with Half-Rate Memory Write

This block takes 16-bit words that arrive one per clock while a valid strobe is high and joins each two consecutive words into one 32-bit word. It then writes that word into a local 128 x 32 memory. Each write stays on the memory port for two input clocks, so the memory side works at half the input rate. The clock for that half rate is not generated inside the block. It is modelled as an alternate-cycle slot that is aligned to the pairing.

A completed pair is first held in a packing register. It is then copied into a second register that drives the memory data input. This second copy keeps the data and the address steady for the whole two-cycle write window, so the early half and the late half of a pair both have the same setup margin.

A combinational read port and a running count of stored words are provided so that the memory contents can be observed.

Top module: `hword_packer`

## Requirements
- R1: While reset is asserted, and at the first clock after it is released, `mem_we` is 0, `mem_addr` is 0 and `words_written` is 0.
- R2: In each packed word, the earlier 16-bit word of a pair occupies bits 31:16 and the later word occupies bits 15:0.
- R3: A pair completed at clock edge n is presented on `mem_wdata` after edge n+1. It stays unchanged through the clock after edge n+2.
- R4: For each completed pair, `mem_we` is high for exactly two input cycles, after edges n+1 and n+2. The memory entry is written at edge n+3.
- R5: The write address is 0 after reset. It rises by one after each write and wraps from 127 back to 0.
- R6: If valid is low in the cycle after an unpaired first word, that word is discarded. Pairing restarts with the next valid word as a first word.
- R7: `words_written` rises by one at each memory write and is unchanged otherwise.
- R8: `rd_data` shows, without a clock, the entry selected by `rd_addr`.
- R9: With valid held high, a write completes every two cycles and no pair is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies in_data this cycle |
| in_data | input | 16 | Incoming half-word |
| rd_addr | input | 7 | Read port address |
| rd_data | output | 32 | Read port data |
| mem_we | output | 1 | Memory write enable, two cycles per pair |
| mem_addr | output | 7 | Memory write address |
| mem_wdata | output | 32 | Double-buffered write data |
| words_written | output | 16 | Number of 32-bit words stored |

## Verification
Several corner cases are covered. A first word left without a partner is tested both with a gap and with the stream resuming. If that word leaked in, every later pair would come out with its halves swapped. A continuous stream is run long enough to wrap the address several times. A design that drops a pair when a new load coincides with the end of a write window shows up as missing words there. A design that fails to wrap overwrites nothing past entry 127 and leaves stale data at the readback. The write data is compared on both cycles of each window, so a single-buffered design that changes data mid-window is also caught.

// File: rtl/hword_packer.sv
module hword_packer #(
  parameter int IN_W  = 16,
  parameter int DEPTH = 128,
  parameter int CNT_W = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int OW   = 2 * IN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [OW-1:0]    rd_data,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [OW-1:0]    mem_wdata,
  output logic [CNT_W-1:0] words_written
);

  logic            have_hi;
  logic [IN_W-1:0] hi_q;
  logic [OW-1:0]   pack_q;
  logic            pack_v;
  logic            we_q;
  logic            wr_slot;
  logic [OW-1:0]   wdata_q;
  logic [AW-1:0]   addr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OW-1:0]   mem [DEPTH];

  wire commit = we_q & wr_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_hi <= 1'b0;
      hi_q    <= '0;
      pack_q  <= '0;
      pack_v  <= 1'b0;
    end else begin
      pack_v <= in_valid & have_hi;
      if (!in_valid) begin
        have_hi <= 1'b0;
      end else if (have_hi) begin
        pack_q  <= {hi_q, in_data};
        have_hi <= 1'b0;
      end else begin
        hi_q    <= in_data;
        have_hi <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      wr_slot <= 1'b0;
      wdata_q <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
    end else begin
      if (pack_v) begin
        wdata_q <= pack_q;
        we_q    <= 1'b1;
        wr_slot <= 1'b0;
      end else if (we_q && !wr_slot) begin
        wr_slot <= 1'b1;
      end else begin
        we_q    <= 1'b0;
        wr_slot <= 1'b0;
      end
      if (commit) begin
        addr_q <= (addr_q == AW'(DEPTH - 1)) ? '0 : addr_q + 1'b1;
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) mem[addr_q] <= wdata_q;
  end

  assign rd_data       = mem[rd_addr];
  assign mem_we        = we_q;
  assign mem_addr      = addr_q;
  assign mem_wdata     = wdata_q;
  assign words_written = cnt_q;

endmodule

// File: rtl/hword_packer_chk.sv
module hword_packer_chk #(
  parameter int AW = 7,
  parameter int OW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_we,
  input logic          wr_slot,
  input logic [AW-1:0] mem_addr,
  input logic [OW-1:0] mem_wdata,
  input logic [CW-1:0] words_written
);

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (!mem_we && mem_addr == '0 && words_written == '0);
    end
  end

  assert_wdata_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && wr_slot) |-> ($stable(mem_wdata) && $stable(mem_addr)));

  assert_we_two_cycles_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !wr_slot) |=> (mem_we && wr_slot));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && wr_slot) |=> (mem_addr == AW'($past(mem_addr) + 1'b1)));

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && wr_slot) |=> $stable(mem_addr));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && wr_slot) |=> (words_written == CW'($past(words_written) + 1'b1)));

endmodule

bind hword_packer hword_packer_chk #(.AW(AW), .OW(OW), .CW(CNT_W)) chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .wr_slot(wr_slot),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .words_written(words_written)
);

// File: tb/hword_packer_test.sv
module hword_packer_test;
  localparam int CLK_PERIOD = 6;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [15:0] in_data = '0;
  logic [6:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        mem_we;
  logic [6:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic [15:0] words_written;

  hword_packer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .words_written(words_written)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  bit m_half = 0;
  logic [15:0] m_hi;
  logic [31:0] qd[$];
  int qs[$];
  logic [31:0] mmem [128];
  bit written [128];
  int maddr = 0, mcnt = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [15:0] d);
    in_valid = v;
    in_data  = d;
    @(posedge clk);
    cyc++;
    if (v) begin
      if (m_half) begin
        qd.push_back({m_hi, d});
        qs.push_back(cyc);
        m_half = 0;
      end else begin
        m_hi = d;
        m_half = 1;
      end
    end else m_half = 0;
    @(negedge clk);
    while (qs.size() > 0 && qs[0] + 3 <= cyc) begin
      mmem[maddr] = qd.pop_front();
      written[maddr] = 1;
      void'(qs.pop_front());
      maddr = (maddr + 1) % 128;
      mcnt++;
    end
    if (qs.size() > 0 && qs[0] + 1 <= cyc) begin
      chk("R4 we", 32'(mem_we), 32'd1);
      chk("R2 R3 R6 wdata", mem_wdata, qd[0]);
      chk("R5 addr", 32'(mem_addr), 32'(maddr));
    end else begin
      chk("R4 we idle", 32'(mem_we), 32'd0);
    end
    chk("R7 count", 32'(words_written), 32'(mcnt));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk("R1 we", 32'(mem_we), 32'd0);
    chk("R1 addr", 32'(mem_addr), 32'd0);
    chk("R1 count", 32'(words_written), 32'd0);
    rst_n = 1;
    step(0, '0);
    chk("R1 we after release", 32'(mem_we), 32'd0);

    step(1, 16'hA1A1); step(1, 16'hB2B2);
    repeat (5) step(0, '0);

    step(1, 16'hDEAD); step(0, '0);
    step(1, 16'h1234); step(1, 16'h5678);
    repeat (4) step(0, '0);
    chk("R6 discard then restart", mmem[(maddr + 127) % 128], 32'h12345678);

    step(1, 16'h0F0F); step(1, 16'hF0F0); step(1, 16'h7777);
    repeat (4) step(0, '0);

    base = mcnt;
    for (int i = 0; i < 600; i++) step(1, 16'(i * 37 + 5));
    repeat (5) step(0, '0);
    chk("R9 stream pairs stored", 32'(mcnt - base), 32'd300);

    for (int i = 0; i < 3000; i++) step(($urandom % 4) != 0, 16'($urandom));
    repeat (6) step(0, '0);

    for (int a = 0; a < 128; a++) begin
      rd_addr = 7'(a);
      #1;
      if (written[a]) chk("R8 readback", rd_data, mmem[a]);
    end
    chk("R5 wrapped", 32'(mcnt > 128), 32'd1);
    summary();
  end
endmodule